// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Incrementing Subaddress

This block is a target on a two-wire serial bus (I2C-compatible). It is oversampled by a fast system clock and exposes a small register map. Three bytes of a frequency readout and one status byte come in on ports and can be read. Three control bytes can be written, and they drive output ports. The serial clock and data lines are brought into the system clock domain through synchronizers. Start and stop conditions are found there from level changes. The data line is modelled as a plain input plus an output-enable that pulls it low.

A transaction opens with a device address byte. Its top bit is 1, bit 5 is taken from a strap pin, and the low five bits come from a parameter. In a write, the next byte selects a starting subaddress, and each data byte after it lands on the current subaddress. The subaddress then steps to the next populated location. A read, usually after a repeated start, returns bytes from the current subaddress. Each byte the master acknowledges advances the subaddress in the same way. Selected bits of the second control byte raise a one-cycle pulse when software clears them after setting them, so a control action is triggered by writing 1 and then 0.

Top module: `i2c_regmap_slave`

## Requirements
- R1: The device address is {1, addr_pin, ADDR_LOW[4:0]} in bits 7..1 of the first byte, and bit 0 is the direction (1 = read, 0 = write). Any other address gets no acknowledge, and the bytes after it in that transfer are neither acknowledged nor written.
- R2: Bytes travel MSB first. The slave acknowledges an accepted address byte, subaddress byte or write data byte by asserting sda_oe (pulling SDA low) throughout the 9th SCL high phase. It releases SDA after that clock.
- R3: The populated subaddresses, in auto-increment order, are 0x00, 0x01, 0x02, 0x04, 0x08, 0x09 and 0x11. A write to 0x08, 0x09 or 0x11 updates ctl_a, ctl_b or ctl_c respectively. A write to 0x00..0x04 is acknowledged and changes nothing.
- R4: A subaddress byte that is not one of the seven populated values gets no acknowledge. The slave then goes idle, so a following data byte is neither acknowledged nor written.
- R5: A read returns, MSB first, freq_in[7:0], freq_in[15:8], freq_in[23:16], status_in, ctl_a, ctl_b or ctl_c for subaddress 0x00, 0x01, 0x02, 0x04, 0x08, 0x09 or 0x11. A master acknowledge advances the subaddress to the next populated one. A read uses the subaddress left by the preceding write phase.
- R6: Once the subaddress has reached 0x11, further read bytes keep returning ctl_c until the master does not acknowledge. The slave then releases SDA and goes idle.
- R7: A stop condition at any point makes the slave idle with SDA released. A start condition at any point, including mid-byte, restarts address reception. A byte cut short by either writes nothing.
- R8: After reset, ctl_a, ctl_b and ctl_c are 0x00, ctl_b_pulse is 0, sda_oe is 0, and the subaddress is 0x00.
- R9: ctl_b_pulse[i] is high for exactly one system clock when a write to 0x09 changes ctl_b[i] from 1 to 0 and PULSE_MASK[i] is 1 (default mask 0x64: bits 6, 5 and 2). Other bits never pulse.
- R10: Once the subaddress has reached 0x11, further write bytes in the same transfer keep landing on ctl_c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_pin | input | 1 | Strap supplying device address bit 5 |
| freq_in | input | 24 | Frequency readout, byte 0 in bits 7:0 |
| status_in | input | 8 | Status byte returned at subaddress 0x04 |
| ctl_a | output | 8 | Control byte at subaddress 0x08 |
| ctl_b | output | 8 | Control byte at subaddress 0x09 |
| ctl_c | output | 8 | Control byte at subaddress 0x11 |
| ctl_b_pulse | output | 8 | One-cycle pulses on masked 1-to-0 clears of ctl_b |

## Verification
The bench builds the block with its defaults: two synchronizer stages, ADDR_LOW = 0 and PULSE_MASK = 0x64. With those values the whole 7-bit address space can be swept for both strap values, and every subaddress from 0x00 to 0x1F plus two high values can be swept for acknowledge. The seven-entry map is small enough that a single burst walks the full auto-increment order, saturates at the top, and shows the repeat behaviour on reads and writes. Aborts by stop and by repeated start are placed mid-byte, where a partially shifted byte must not be committed.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  localparam int BYTE_W     = 8;
  localparam int FREQ_BYTES = 3;
  localparam int DEV_W      = 7;

  typedef logic [BYTE_W-1:0] byte_t;

  // Populated subaddresses; the auto-increment order follows this list.
  localparam byte_t SA_FREQ0  = 8'h00;
  localparam byte_t SA_FREQ1  = 8'h01;
  localparam byte_t SA_FREQ2  = 8'h02;
  localparam byte_t SA_STATUS = 8'h04;
  localparam byte_t SA_CTL_A  = 8'h08;
  localparam byte_t SA_CTL_B  = 8'h09;
  localparam byte_t SA_CTL_C  = 8'h11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_SUB,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_MACK
  } st_e;

  function automatic logic sa_valid(input byte_t a);
    case (a)
      SA_FREQ0, SA_FREQ1, SA_FREQ2, SA_STATUS,
      SA_CTL_A, SA_CTL_B, SA_CTL_C: sa_valid = 1'b1;
      default:                      sa_valid = 1'b0;
    endcase
  endfunction

  function automatic byte_t sa_next(input byte_t a);
    case (a)
      SA_FREQ0:  sa_next = SA_FREQ1;
      SA_FREQ1:  sa_next = SA_FREQ2;
      SA_FREQ2:  sa_next = SA_STATUS;
      SA_STATUS: sa_next = SA_CTL_A;
      SA_CTL_A:  sa_next = SA_CTL_B;
      default:   sa_next = SA_CTL_C;
    endcase
  endfunction

endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LINES = 2;
  localparam int SCL_IX = 0;
  localparam int SDA_IX = 1;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] lvl_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;
    if (STAGES > 1) begin : g_multi
      assign pipe_d = {pipe_q[STAGES-2:0], raw[g]};
    end else begin : g_single
      assign pipe_d = raw[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= pipe_d;
    end
    assign lvl[g] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl;
  end

  assign scl_lvl   = lvl[SCL_IX];
  assign sda_lvl   = lvl[SDA_IX];
  assign scl_rise  =  lvl[SCL_IX] & ~lvl_q[SCL_IX];
  assign scl_fall  = ~lvl[SCL_IX] &  lvl_q[SCL_IX];
  assign start_det =  lvl[SCL_IX] &  lvl_q[SCL_IX] & ~lvl[SDA_IX] &  lvl_q[SDA_IX];
  assign stop_det  =  lvl[SCL_IX] &  lvl_q[SCL_IX] &  lvl[SDA_IX] & ~lvl_q[SDA_IX];

endmodule

// File: rtl/i2cr_proto.sv
module i2cr_proto
  import i2cr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [DEV_W-1:0] dev_addr,
  input  byte_t            rd_data,
  output logic             wr_en,
  output byte_t            wr_data,
  output byte_t            ptr,
  output logic             sda_oe
);

  st_e        state_q, state_d;
  st_e        after_q, after_d;
  logic [3:0] bit_q, bit_d;
  byte_t      rx_q, rx_d;
  byte_t      tx_q, tx_d;
  byte_t      ptr_q, ptr_d;
  logic       oe_q, oe_d;
  logic       acked_q, acked_d;
  logic       mack_q, mack_d;
  byte_t      byte_in;
  logic       last_bit;

  assign byte_in  = {rx_q[BYTE_W-2:0], sda_lvl};
  assign last_bit = (bit_q == 4'd7);

  always_comb begin
    state_d = state_q;
    after_d = after_q;
    bit_d   = bit_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    acked_d = acked_q;
    mack_d  = mack_q;
    wr_en   = 1'b0;
    if (start_det) begin
      state_d = ST_DEV;
      bit_d   = 4'd0;
      oe_d    = 1'b0;
      acked_d = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_SUB, ST_WDATA: begin
          if (scl_rise) begin
            rx_d  = byte_in;
            bit_d = bit_q + 4'd1;
            if (last_bit) begin
              bit_d   = 4'd0;
              acked_d = 1'b0;
              case (state_q)
                ST_DEV: begin
                  if (byte_in[BYTE_W-1:1] == dev_addr) begin
                    state_d = ST_ACK;
                    after_d = byte_in[0] ? ST_RDATA : ST_SUB;
                  end else begin
                    state_d = ST_IDLE;
                  end
                end
                ST_SUB: begin
                  if (sa_valid(byte_in)) begin
                    ptr_d   = byte_in;
                    state_d = ST_ACK;
                    after_d = ST_WDATA;
                  end else begin
                    state_d = ST_IDLE;
                  end
                end
                default: begin
                  wr_en   = 1'b1;
                  ptr_d   = sa_next(ptr_q);
                  state_d = ST_ACK;
                  after_d = ST_WDATA;
                end
              endcase
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!acked_q) begin
              oe_d    = 1'b1;
              acked_d = 1'b1;
            end else begin
              acked_d = 1'b0;
              state_d = after_q;
              bit_d   = 4'd0;
              if (after_q == ST_RDATA) begin
                tx_d = rd_data;
                oe_d = ~rd_data[BYTE_W-1];
              end else begin
                oe_d = 1'b0;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_d = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d    = 1'b0;
              bit_d   = 4'd0;
              state_d = ST_MACK;
            end else begin
              tx_d = {tx_q[BYTE_W-2:0], 1'b0};
              oe_d = ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
            if (!sda_lvl) ptr_d = sa_next(ptr_q);
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RDATA;
              tx_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              bit_d   = 4'd0;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      after_q <= ST_IDLE;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= SA_FREQ0;
      oe_q    <= 1'b0;
      acked_q <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      after_q <= after_d;
      bit_q   <= bit_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      acked_q <= acked_d;
      mack_q  <= mack_d;
    end
  end

  assign wr_data = byte_in;
  assign ptr     = ptr_q;
  assign sda_oe  = oe_q;

  // R2: the data line is only ever grabbed while SCL is low
  a_r2_grab_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_lvl);

  // R7: a stop condition leaves the slave idle with the line released
  a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!oe_q && state_q == ST_IDLE));

  // R7: a start condition always restarts address reception
  a_r7_start_dev: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_DEV && bit_q == 4'd0));

  // R4: the subaddress pointer never holds an unpopulated location
  a_r4_ptr_populated: assert property (@(posedge clk) disable iff (!rst_n)
    sa_valid(ptr_q));

  // R10: once at the top, the pointer stays there until a new subaddress
  a_r10_top_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == SA_CTL_C && state_q != ST_SUB) |=> ptr_q == SA_CTL_C);

endmodule

// File: rtl/i2cr_regbank.sv
module i2cr_regbank
  import i2cr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PULSE_MASK = 8'h64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  byte_t                      wr_addr,
  input  byte_t                      wr_data,
  input  byte_t                      rd_addr,
  input  logic [FREQ_BYTES*BYTE_W-1:0] freq_in,
  input  byte_t                      status_in,
  output byte_t                      rd_data,
  output byte_t                      ctl_a,
  output byte_t                      ctl_b,
  output byte_t                      ctl_c,
  output byte_t                      ctl_b_pulse
);

  byte_t a_q, b_q, c_q;
  byte_t pulse_d, pulse_q;
  logic  en_a, en_b, en_c;

  assign en_a = wr_en && (wr_addr == SA_CTL_A);
  assign en_b = wr_en && (wr_addr == SA_CTL_B);
  assign en_c = wr_en && (wr_addr == SA_CTL_C);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_pulse
    if (PULSE_MASK[i]) begin : g_on
      assign pulse_d[i] = en_b & b_q[i] & ~wr_data[i];
    end else begin : g_off
      assign pulse_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      pulse_q <= '0;
    end else begin
      if (en_a) a_q <= wr_data;
      if (en_b) b_q <= wr_data;
      if (en_c) c_q <= wr_data;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    case (rd_addr)
      SA_FREQ0:  rd_data = freq_in[0*BYTE_W +: BYTE_W];
      SA_FREQ1:  rd_data = freq_in[1*BYTE_W +: BYTE_W];
      SA_FREQ2:  rd_data = freq_in[2*BYTE_W +: BYTE_W];
      SA_STATUS: rd_data = status_in;
      SA_CTL_A:  rd_data = a_q;
      SA_CTL_B:  rd_data = b_q;
      SA_CTL_C:  rd_data = c_q;
      default:   rd_data = '0;
    endcase
  end

  assign ctl_a       = a_q;
  assign ctl_b       = b_q;
  assign ctl_c       = c_q;
  assign ctl_b_pulse = pulse_q;

  // R9: a pulse only follows a write strobe aimed at control B
  a_r9_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_q) |-> $past(wr_en && wr_addr == SA_CTL_B));

  // R9: a pulsing bit is cleared in the register it comes from
  a_r9_pulse_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q & b_q) == '0);

  // R9: pulses last one cycle
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_q) |=> (pulse_q & $past(pulse_q)) == '0);

  // R3: control bytes move only on a write strobe
  a_r3_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({a_q, b_q, c_q}));

endmodule

// File: rtl/i2c_regmap_slave.sv
module i2c_regmap_slave
  import i2cr_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [4:0]  ADDR_LOW    = 5'b00000,
  parameter logic [7:0]  PULSE_MASK  = 8'h64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic        addr_pin,
  input  logic [23:0] freq_in,
  input  logic [7:0]  status_in,
  output logic [7:0]  ctl_a,
  output logic [7:0]  ctl_b,
  output logic [7:0]  ctl_c,
  output logic [7:0]  ctl_b_pulse
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  byte_t            wr_data, ptr, rd_data;
  logic [DEV_W-1:0] dev_addr;

  assign dev_addr = {1'b1, addr_pin, ADDR_LOW};

  i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cr_proto u_proto (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_addr  (dev_addr),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ptr       (ptr),
    .sda_oe    (sda_oe)
  );

  i2cr_regbank #(.PULSE_MASK(PULSE_MASK)) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_en       (wr_en),
    .wr_addr     (ptr),
    .wr_data     (wr_data),
    .rd_addr     (ptr),
    .freq_in     (freq_in),
    .status_in   (status_in),
    .rd_data     (rd_data),
    .ctl_a       (ctl_a),
    .ctl_b       (ctl_b),
    .ctl_c       (ctl_c),
    .ctl_b_pulse (ctl_b_pulse)
  );

endmodule

// File: tb/i2c_regmap_slave_tb.sv
module i2c_regmap_slave_tb;

  localparam int HP       = 10;
  localparam int WDOG_LIM = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        addr_pin = 1'b0;
  logic [23:0] freq_in = 24'h5A3C96;
  logic [7:0]  status_in = 8'hC7;
  logic        sda_oe;
  logic        bus_sda;
  logic [7:0]  ctl_a, ctl_b, ctl_c, ctl_b_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;
  bit pclr   = 1'b0;
  int pcnt [8];

  logic [7:0] m_a = 8'h00, m_b = 8'h00, m_c = 8'h00;

  assign bus_sda = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regmap_slave u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (m_scl),
    .sda_i       (bus_sda),
    .sda_oe      (sda_oe),
    .addr_pin    (addr_pin),
    .freq_in     (freq_in),
    .status_in   (status_in),
    .ctl_a       (ctl_a),
    .ctl_b       (ctl_b),
    .ctl_c       (ctl_c),
    .ctl_b_pulse (ctl_b_pulse)
  );

  always @(negedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (pclr) pcnt[i] = 0;
      else if (ctl_b_pulse[i]) pcnt[i] = pcnt[i] + 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_LIM && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WDOG_LIM);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wclk(HP);
    m_scl = 1'b1; wclk(HP);
    m_sda = 1'b0; wclk(HP);
    m_scl = 1'b0; wclk(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wclk(HP);
    m_scl = 1'b1; wclk(HP);
    m_sda = 1'b1; wclk(HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wclk(HP);
      m_scl = 1'b1; wclk(HP);
      m_scl = 1'b0; wclk(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; wclk(HP);
    m_scl = 1'b1; wclk(HP / 2);
    ack = ~bus_sda;
    wclk(HP / 2);
    m_scl = 1'b0; wclk(2);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(HP);
      m_scl = 1'b1; wclk(HP / 2);
      b[i] = bus_sda;
      wclk(HP / 2);
      m_scl = 1'b0; wclk(2);
    end
    m_sda = ~mack; wclk(HP);
    m_scl = 1'b1; wclk(HP);
    m_scl = 1'b0; wclk(2);
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] sa);
    case (sa)
      8'h00:   exp_read = freq_in[7:0];
      8'h01:   exp_read = freq_in[15:8];
      8'h02:   exp_read = freq_in[23:16];
      8'h04:   exp_read = status_in;
      8'h08:   exp_read = m_a;
      8'h09:   exp_read = m_b;
      8'h11:   exp_read = m_c;
      default: exp_read = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_next(input logic [7:0] sa);
    case (sa)
      8'h00:   exp_next = 8'h01;
      8'h01:   exp_next = 8'h02;
      8'h02:   exp_next = 8'h04;
      8'h04:   exp_next = 8'h08;
      8'h08:   exp_next = 8'h09;
      default: exp_next = 8'h11;
    endcase
  endfunction

  function automatic logic exp_valid(input logic [7:0] sa);
    exp_valid = (sa == 8'h00) || (sa == 8'h01) || (sa == 8'h02) || (sa == 8'h04) ||
                (sa == 8'h08) || (sa == 8'h09) || (sa == 8'h11);
  endfunction

  task automatic write_one(input logic [7:0] sa, input logic [7:0] d);
    logic ack;
    bus_start();
    send_byte(8'h80, ack); chk("R2 addr ack", ack, 1'b1);
    send_byte(sa, ack);    chk("R2 sub ack", ack, 1'b1);
    send_byte(d, ack);     chk("R2 data ack", ack, 1'b1);
    bus_stop();
  endtask

  initial begin
    logic       ack;
    logic [7:0] rb;
    logic [7:0] sa;
    logic [7:0] sub_list [34];

    wclk(5);
    rst_n = 1'b1;
    wclk(10);

    // R8: reset state
    chk("R8 ctl_a reset", ctl_a, 8'h00);
    chk("R8 ctl_b reset", ctl_b, 8'h00);
    chk("R8 ctl_c reset", ctl_c, 8'h00);
    chk("R8 pulse reset", ctl_b_pulse, 8'h00);
    chk("R8 sda_oe reset", sda_oe, 1'b0);

    // R8/R5: read with no prior subaddress starts at 0x00
    bus_start();
    send_byte(8'h81, ack); chk("R5 read addr ack", ack, 1'b1);
    recv_byte(1'b0, rb);   chk("R8 first read at 0x00", rb, freq_in[7:0]);
    bus_stop();

    // R1: sweep every address for both strap values
    for (int p = 0; p < 2; p++) begin
      addr_pin = p[0];
      wclk(4);
      for (int a = 0; a < 128; a++) begin
        bus_start();
        send_byte({a[6:0], 1'b0}, ack);
        chk($sformatf("R1 addr %0h pin %0d", a, p), ack, (a == (64 + 32 * p)) ? 1'b1 : 1'b0);
        bus_stop();
      end
    end
    addr_pin = 1'b0;
    wclk(4);

    // R1: a foreign address does not write the following bytes
    bus_start();
    send_byte(8'hA0, ack); chk("R1 foreign addr nack", ack, 1'b0);
    send_byte(8'h08, ack); chk("R1 foreign sub nack", ack, 1'b0);
    send_byte(8'hEE, ack); chk("R1 foreign data nack", ack, 1'b0);
    bus_stop();
    chk("R1 ctl_a untouched", ctl_a, m_a);

    // R3/R10: burst write from 0x08 through the top and beyond
    bus_start();
    send_byte(8'h80, ack); chk("R2 addr ack", ack, 1'b1);
    send_byte(8'h08, ack); chk("R2 sub ack", ack, 1'b1);
    send_byte(8'h11, ack); chk("R3 w 0x08 ack", ack, 1'b1);
    send_byte(8'h22, ack); chk("R3 w 0x09 ack", ack, 1'b1);
    send_byte(8'h33, ack); chk("R3 w 0x11 ack", ack, 1'b1);
    send_byte(8'h44, ack); chk("R10 w past top ack", ack, 1'b1);
    bus_stop();
    m_a = 8'h11; m_b = 8'h22; m_c = 8'h44;
    chk("R3 ctl_a", ctl_a, m_a);
    chk("R3 ctl_b", ctl_b, m_b);
    chk("R10 ctl_c holds last", ctl_c, m_c);

    // R3: writes to read-only locations acked and ignored, fifth lands on 0x08
    bus_start();
    send_byte(8'h80, ack);
    send_byte(8'h00, ack);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'h01 + k[7:0], ack); chk("R3 ro write ack", ack, 1'b1);
    end
    send_byte(8'h5A, ack); chk("R3 step to 0x08 ack", ack, 1'b1);
    bus_stop();
    m_a = 8'h5A;
    chk("R3 ctl_a after ro walk", ctl_a, m_a);
    chk("R3 ctl_b untouched", ctl_b, m_b);

    // R5/R6: full read walk with repeated start, saturating at the top
    bus_start();
    send_byte(8'h80, ack);
    send_byte(8'h00, ack);
    bus_start();
    send_byte(8'h81, ack); chk("R5 read addr ack", ack, 1'b1);
    sa = 8'h00;
    for (int k = 0; k < 10; k++) begin
      recv_byte(k != 9, rb);
      chk($sformatf("R5 R6 read byte %0d at %0h", k, sa), rb, exp_read(sa));
      sa = exp_next(sa);
    end
    chk("R6 released after nack", sda_oe, 1'b0);
    bus_stop();

    // R5: read starting mid-map (MSB-first ordering of status)
    bus_start();
    send_byte(8'h80, ack);
    send_byte(8'h04, ack);
    bus_start();
    send_byte(8'h81, ack);
    recv_byte(1'b1, rb); chk("R5 status byte", rb, status_in);
    recv_byte(1'b0, rb); chk("R5 ctl_a byte", rb, m_a);
    bus_stop();

    // R4: subaddress sweep
    for (int k = 0; k < 32; k++) sub_list[k] = k[7:0];
    sub_list[32] = 8'h80;
    sub_list[33] = 8'hFF;
    for (int k = 0; k < 34; k++) begin
      bus_start();
      send_byte(8'h80, ack);
      send_byte(sub_list[k], ack);
      chk($sformatf("R4 sub %0h ack", sub_list[k]), ack, exp_valid(sub_list[k]));
      bus_stop();
    end

    // R4: data after a refused subaddress is ignored
    bus_start();
    send_byte(8'h80, ack);
    send_byte(8'h03, ack); chk("R4 sub 0x03 nack", ack, 1'b0);
    send_byte(8'hFF, ack); chk("R4 data after nack", ack, 1'b0);
    bus_stop();
    chk("R4 ctl_a unchanged", ctl_a, m_a);
    chk("R4 ctl_b unchanged", ctl_b, m_b);

    // R9: clearing bits of ctl_b
    write_one(8'h09, 8'hFF); m_b = 8'hFF;
    pclr = 1'b1; wclk(2); pclr = 1'b0;
    write_one(8'h09, 8'h00); m_b = 8'h00;
    for (int i = 0; i < 8; i++)
      chk($sformatf("R9 pulse count bit %0d", i), pcnt[i], (i == 2 || i == 5 || i == 6) ? 1 : 0);
    chk("R9 ctl_b cleared", ctl_b, 8'h00);
    write_one(8'h09, 8'h00);
    for (int i = 0; i < 8; i++)
      chk($sformatf("R9 no pulse on 0-to-0 bit %0d", i), pcnt[i], (i == 2 || i == 5 || i == 6) ? 1 : 0);

    // R7: stop in mid-byte commits nothing
    bus_start();
    send_byte(8'h80, ack);
    send_byte(8'h08, ack);
    send_bits(8'hF0, 4);
    bus_stop();
    chk("R7 stop mid-byte ctl_a", ctl_a, m_a);
    chk("R7 stop releases", sda_oe, 1'b0);

    // R7: start in mid-byte restarts address reception
    bus_start();
    send_byte(8'h80, ack);
    send_byte(8'h09, ack);
    send_bits(8'hAA, 3);
    bus_start();
    send_byte(8'h80, ack); chk("R7 restart addr ack", ack, 1'b1);
    send_byte(8'h08, ack); chk("R7 restart sub ack", ack, 1'b1);
    send_byte(8'h77, ack); chk("R7 restart data ack", ack, 1'b1);
    bus_stop();
    m_a = 8'h77;
    chk("R7 ctl_a after restart", ctl_a, m_a);
    chk("R7 ctl_b untouched", ctl_b, m_b);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule